// File: doc/BRIEF.md
# Seven-Stage Pipeline Hazard and Forwarding Control

This block decides, for an in-order pipeline with the stages IF, ID, REG, EX1, EX2, MEM and WB, whether the instruction now sitting in REG may advance. If it may, the block also says where each of its two source operands should be taken from on the way into EX1. The register file is read in REG and written in WB. A result becomes usable at a point that depends on the kind of instruction that makes it. A logical operation (and, or, shift) has its value at the end of EX1. An arithmetic operation (add, sub) has it at the end of EX2. A load has its data at the end of MEM, and a load's address, like any arithmetic operand, is needed as EX1 begins.

The block keeps its own shadow copy of the destination register, write enable and operation class for each stage from EX1 to WB. It loads the EX1 copy from the REG-stage inputs whenever an instruction issues. For each operand it finds the youngest in-flight writer of that register. It then either names that writer's stage as the forwarding source, or raises `stall` when the value does not exist yet.

During a stall the surrounding pipeline holds IF, ID and REG, and the block puts a bubble with writing disabled into EX1. The datapath multiplexers and the register file are outside the block.

Top module: `pipe_hazard_fwd`

## Requirements
- R1: After reset all shadow stages are empty. With `reg_vld` low, `stall` is 0 and both selects are 0. The first instruction issued after reset sees no producers.
- R2: A logical producer (class code 2'b00) in EX1 that matches a source gives that operand select 1 (EX1) and causes no stall.
- R3: An arithmetic producer (class code 2'b01) in EX1 that matches a source stalls the consumer for exactly one cycle. On the following cycle the consumer gets select 2 (EX2).
- R4: A load producer (class code 2'b10) stalls a matching consumer while the load is in EX1 or EX2. That is two cycles when adjacent and one cycle at distance two. The consumer then gets select 3 (MEM).
- R5: Select codes name the youngest matching producer's stage: 0 register file, 1 EX1, 2 EX2, 3 MEM, 4 WB. A producer one to four issue slots older lands in EX1 to WB respectively. A producer five or more slots older is no longer tracked and gives 0.
- R6: When several in-flight instructions write the source register, the youngest one wins. EX1 takes precedence over EX2, EX2 over MEM, and MEM over WB.
- R7: Source register 0 never yields a nonzero select and never causes a stall, even if an in-flight instruction names register 0 as its destination.
- R8: A stall keeps the REG instruction in place and puts a non-writing bubble into EX1. The stalled instruction enters EX1 once, on the cycle `stall` falls, and the bubble advances through the stages ahead of it.
- R9: The two operands are resolved independently, each with its own select. `stall` is raised if either operand needs it.
- R10: An in-flight instruction with `reg_wen` low is never a forwarding source and never causes a stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_vld | input | 1 | REG holds a valid instruction |
| reg_rd | input | RIDX_W | Destination register of the REG instruction |
| reg_wen | input | 1 | REG instruction writes its destination |
| reg_cls | input | 2 | Operation class: 00 logical, 01 arithmetic, 10 load |
| reg_rs1 | input | RIDX_W | First source register (0 = unused) |
| reg_rs2 | input | RIDX_W | Second source register (0 = unused) |
| stall | output | 1 | Hold IF/ID/REG and insert a bubble into EX1 |
| fwd_sel_a | output | 3 | Source select for operand A entering EX1 |
| fwd_sel_b | output | 3 | Source select for operand B entering EX1 |

## Verification
Some properties are checked on every cycle:
- a stall is followed by a non-writing EX1 slot;
- an arithmetic producer immediately ahead of a reader always stalls it;
- no run of stalls exceeds two cycles;
- a logical producer in EX1 is always chosen for a matching operand;
- register 0 never selects a forwarding path.

The exact stall counts and select codes for each distance, the precedence among several writers of one register, and the independent handling of the two operands can only be shown by the bench's instruction sequences. The same holds for the way a bubble shifts older producers one stage further away.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  typedef enum logic [1:0] {
    CLS_LOGIC = 2'b00,
    CLS_ARITH = 2'b01,
    CLS_LOAD  = 2'b10
  } op_cls_e;

  // Select encoding: 0 register file, 1..4 = EX1..WB.
  localparam int SEL_W = 3;

  // Is the result of a producer of class cls available at the end of
  // shadow stage stg (0 = EX1, 1 = EX2, 2 = MEM, 3 = WB)?
  function automatic logic result_ready(logic [1:0] cls, int stg);
    logic rdy;
    case (stg)
      0:       rdy = (cls == CLS_LOGIC);
      1:       rdy = (cls == CLS_LOGIC) || (cls == CLS_ARITH);
      default: rdy = 1'b1;
    endcase
    return rdy;
  endfunction

  // Shadow stage index to forwarding select code.
  function automatic logic [SEL_W-1:0] stage_sel(int stg);
    return SEL_W'(stg + 1);
  endfunction

endpackage

// File: rtl/hzd_slot_pipe.sv
module hzd_slot_pipe #(
  parameter int RIDX_W = 5,
  parameter int NSTG   = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load_en,
  input  logic [RIDX_W-1:0]            in_rd,
  input  logic                         in_wen,
  input  logic [1:0]                   in_cls,
  output logic [NSTG-1:0]              slot_wen,
  output logic [NSTG-1:0][RIDX_W-1:0]  slot_rd,
  output logic [NSTG-1:0][1:0]         slot_cls
);

  generate
    for (genvar g = 0; g < NSTG; g++) begin : g_stg
      logic              wen_q;
      logic [RIDX_W-1:0] rd_q;
      logic [1:0]        cls_q;

      if (g == 0) begin : g_head
        // EX1 entry: the issuing instruction, or a non-writing bubble.
        always_ff @(posedge clk) begin
          if (!rst_n) begin
            wen_q <= 1'b0;
            rd_q  <= '0;
            cls_q <= '0;
          end else begin
            wen_q <= load_en & in_wen;
            rd_q  <= in_rd;
            cls_q <= in_cls;
          end
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (!rst_n) begin
            wen_q <= 1'b0;
            rd_q  <= '0;
            cls_q <= '0;
          end else begin
            wen_q <= slot_wen[g-1];
            rd_q  <= slot_rd[g-1];
            cls_q <= slot_cls[g-1];
          end
        end
      end

      assign slot_wen[g] = wen_q;
      assign slot_rd[g]  = rd_q;
      assign slot_cls[g] = cls_q;
    end
  endgenerate

endmodule

// File: rtl/hzd_operand_fwd.sv
module hzd_operand_fwd
  import hzd_pkg::*;
#(
  parameter int RIDX_W = 5,
  parameter int NSTG   = 4
) (
  input  logic [RIDX_W-1:0]            src,
  input  logic [NSTG-1:0]              slot_wen,
  input  logic [NSTG-1:0][RIDX_W-1:0]  slot_rd,
  input  logic [NSTG-1:0][1:0]         slot_cls,
  output logic [SEL_W-1:0]             sel,
  output logic                         need_stall
);

  logic [NSTG-1:0] hit_vec;

  generate
    for (genvar g = 0; g < NSTG; g++) begin : g_cmp
      assign hit_vec[g] = slot_wen[g] && (src != '0) && (slot_rd[g] == src);
    end
  endgenerate

  // Walk oldest to youngest so the youngest match is the last one taken.
  always_comb begin
    sel        = '0;
    need_stall = 1'b0;
    for (int i = NSTG - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        sel        = stage_sel(i);
        need_stall = !result_ready(slot_cls[i], i);
      end
    end
  end

endmodule

// File: rtl/hzd_stall_ctl.sv
module hzd_stall_ctl #(
  parameter int NOPS = 2
) (
  input  logic            reg_vld,
  input  logic [NOPS-1:0] op_need,
  output logic            stall,
  output logic            issue
);

  assign stall = reg_vld && (|op_need);
  assign issue = reg_vld && !stall;

endmodule

// File: rtl/pipe_hazard_fwd.sv
module pipe_hazard_fwd
  import hzd_pkg::*;
#(
  parameter int RIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_vld,
  input  logic [RIDX_W-1:0] reg_rd,
  input  logic              reg_wen,
  input  logic [1:0]        reg_cls,
  input  logic [RIDX_W-1:0] reg_rs1,
  input  logic [RIDX_W-1:0] reg_rs2,
  output logic              stall,
  output logic [2:0]        fwd_sel_a,
  output logic [2:0]        fwd_sel_b
);

  localparam int NSTG = 4;  // EX1, EX2, MEM, WB
  localparam int NOPS = 2;

  logic [NSTG-1:0]             slot_wen;
  logic [NSTG-1:0][RIDX_W-1:0] slot_rd;
  logic [NSTG-1:0][1:0]        slot_cls;

  logic [NOPS-1:0][RIDX_W-1:0] op_src;
  logic [NOPS-1:0][SEL_W-1:0]  op_sel;
  logic [NOPS-1:0]             op_need;

  // Named internal events for the checker.
  logic issue;
  logic ex1_wen;

  assign op_src[0] = reg_rs1;
  assign op_src[1] = reg_rs2;

  hzd_slot_pipe #(.RIDX_W(RIDX_W), .NSTG(NSTG)) u_slots (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (issue),
    .in_rd    (reg_rd),
    .in_wen   (reg_wen),
    .in_cls   (reg_cls),
    .slot_wen (slot_wen),
    .slot_rd  (slot_rd),
    .slot_cls (slot_cls)
  );

  generate
    for (genvar k = 0; k < NOPS; k++) begin : g_op
      hzd_operand_fwd #(.RIDX_W(RIDX_W), .NSTG(NSTG)) u_fwd (
        .src        (op_src[k]),
        .slot_wen   (slot_wen),
        .slot_rd    (slot_rd),
        .slot_cls   (slot_cls),
        .sel        (op_sel[k]),
        .need_stall (op_need[k])
      );
    end
  endgenerate

  hzd_stall_ctl #(.NOPS(NOPS)) u_ctl (
    .reg_vld (reg_vld),
    .op_need (op_need),
    .stall   (stall),
    .issue   (issue)
  );

  assign ex1_wen   = slot_wen[0];
  assign fwd_sel_a = op_sel[0];
  assign fwd_sel_b = op_sel[1];

endmodule

// File: rtl/hzd_checker.sv
module hzd_checker #(
  parameter int RIDX_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_vld,
  input logic [RIDX_W-1:0] reg_rd,
  input logic              reg_wen,
  input logic [1:0]        reg_cls,
  input logic [RIDX_W-1:0] reg_rs1,
  input logic [RIDX_W-1:0] reg_rs2,
  input logic              stall,
  input logic [2:0]        fwd_sel_a,
  input logic [2:0]        fwd_sel_b,
  input logic              issue,
  input logic              ex1_wen,
  input logic [RIDX_W-1:0] ex1_rd,
  input logic [1:0]        ex1_cls
);

  // R8: the cycle after a stall, EX1 holds a non-writing bubble.
  a_r8_bubble_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !ex1_wen);

  // R3: an arithmetic writer issued just ahead of a reader stalls it.
  a_r3_arith_adjacent_stall: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(issue && reg_wen && reg_cls == 2'b01 && reg_rd != '0)
     && reg_vld && reg_rs1 == $past(reg_rd)) |-> stall);

  // R4: no stall run is longer than two cycles.
  a_r4_stall_max_two: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && stall && $past(stall)) |=> !stall);

  // R2: a logical writer in EX1 is chosen for a matching operand.
  a_r2_logical_ex1_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_vld && ex1_wen && ex1_cls == 2'b00 && ex1_rd == reg_rs1 && reg_rs1 != '0)
    |-> (fwd_sel_a == 3'd1));

  // R7: register 0 never selects a forwarding path.
  a_r7_zero_src: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_rs1 == '0) |-> (fwd_sel_a == 3'd0)) and ((reg_rs2 == '0) |-> (fwd_sel_b == 3'd0)));

endmodule

bind pipe_hazard_fwd hzd_checker #(.RIDX_W(RIDX_W)) u_hzd_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_vld   (reg_vld),
  .reg_rd    (reg_rd),
  .reg_wen   (reg_wen),
  .reg_cls   (reg_cls),
  .reg_rs1   (reg_rs1),
  .reg_rs2   (reg_rs2),
  .stall     (stall),
  .fwd_sel_a (fwd_sel_a),
  .fwd_sel_b (fwd_sel_b),
  .issue     (issue),
  .ex1_wen   (ex1_wen),
  .ex1_rd    (slot_rd[0]),
  .ex1_cls   (slot_cls[0])
);

// File: tb/test_pipe_hazard_fwd.sv
module test_pipe_hazard_fwd;

  localparam logic [1:0] LOG = 2'b00;
  localparam logic [1:0] ARI = 2'b01;
  localparam logic [1:0] LDC = 2'b10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_vld = 1'b0;
  logic [4:0] reg_rd = '0;
  logic       reg_wen = 1'b0;
  logic [1:0] reg_cls = '0;
  logic [4:0] reg_rs1 = '0;
  logic [4:0] reg_rs2 = '0;
  logic       stall;
  logic [2:0] fwd_sel_a;
  logic [2:0] fwd_sel_b;

  int tests = 0;
  int fails = 0;
  int st_cnt = 0;

  typedef struct {
    int    st;
    int    a;
    int    b;
    string tag;
  } exp_t;

  exp_t exp_q[$];

  always #4 clk = ~clk;  // 125 MHz

  pipe_hazard_fwd #(.RIDX_W(5)) i_pipe_hazard_fwd (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_vld   (reg_vld),
    .reg_rd    (reg_rd),
    .reg_wen   (reg_wen),
    .reg_cls   (reg_cls),
    .reg_rs1   (reg_rs1),
    .reg_rs2   (reg_rs2),
    .stall     (stall),
    .fwd_sel_a (fwd_sel_a),
    .fwd_sel_b (fwd_sel_b)
  );

  task automatic check(input bit ok, input string what, input int got, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", what, got, exp);
    end
  endtask

  // Monitor: counts stall cycles of the REG instruction, compares on release.
  always @(negedge clk) begin
    if (rst_n && reg_vld) begin
      if (stall) begin
        st_cnt++;
      end else if (exp_q.size() == 0) begin
        check(1'b0, "scoreboard empty on issue", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(st_cnt == e.st, {e.tag, " stall cycles"}, st_cnt, e.st);
        check(int'(fwd_sel_a) == e.a, {e.tag, " select A"}, int'(fwd_sel_a), e.a);
        check(int'(fwd_sel_b) == e.b, {e.tag, " select B"}, int'(fwd_sel_b), e.b);
        st_cnt = 0;
      end
    end
  end

  // Driver: pushes the expected result, presents the instruction in REG
  // and holds it until it issues.
  task automatic issue_op(input logic [4:0] rd, input logic w, input logic [1:0] c,
                          input logic [4:0] s1, input logic [4:0] s2,
                          input int est, input int ea, input int eb, input string tag);
    exp_t e;
    e.st = est; e.a = ea; e.b = eb; e.tag = tag;
    exp_q.push_back(e);
    @(posedge clk);
    #1;
    reg_vld = 1'b1; reg_rd = rd; reg_wen = w; reg_cls = c;
    reg_rs1 = s1; reg_rs2 = s2;
    @(negedge clk);
    while (stall) @(negedge clk);
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      reg_vld = 1'b0; reg_wen = 1'b0; reg_rs1 = '0; reg_rs2 = '0;
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: got 1 expected 0 (run did not complete)");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    // R1: empty after reset
    check(stall == 1'b0, "R1 reset stall", int'(stall), 0);
    check(fwd_sel_a == 3'd0, "R1 reset select A", int'(fwd_sel_a), 0);
    check(fwd_sel_b == 3'd0, "R1 reset select B", int'(fwd_sel_b), 0);

    // Mixed sequence
    issue_op(5'd5,  1, ARI, 5'd4, 5'd1, 0, 0, 0, "R1 first issue after reset");
    issue_op(5'd6,  1, LDC, 5'd5, 5'd0, 1, 2, 0, "R3 arith adjacent");
    issue_op(5'd6,  1, LOG, 5'd6, 5'd4, 2, 3, 0, "R4 load adjacent");
    issue_op(5'd8,  1, ARI, 5'd5, 5'd6, 0, 0, 1, "R6 EX1 over WB");
    issue_op(5'd7,  1, LDC, 5'd5, 5'd0, 0, 0, 0, "R5 retired producer");
    issue_op(5'd9,  1, LOG, 5'd8, 5'd0, 0, 2, 0, "R5 arith in EX2");
    issue_op(5'd10, 1, ARI, 5'd7, 5'd9, 1, 3, 2, "R9 mixed operands");
    nops(6);

    // Distances behind an arithmetic producer (R5)
    for (int d = 1; d <= 4; d++) begin
      issue_op(5'd3, 1, ARI, 5'd1, 5'd2, 0, 0, 0, "R5 producer");
      nops(d);
      issue_op(5'd20, 1, LOG, 5'd3, 5'd0, 0, (d == 4) ? 0 : d + 1, 0, "R5 distance");
      nops(6);
    end

    // Load at distance two (R4)
    issue_op(5'd3, 1, LDC, 5'd1, 5'd0, 0, 0, 0, "R4 load producer");
    nops(1);
    issue_op(5'd21, 1, ARI, 5'd0, 5'd3, 1, 0, 3, "R4 load distance two");
    nops(6);

    // Logical adjacent (R2)
    issue_op(5'd3, 1, LOG, 5'd1, 5'd0, 0, 0, 0, "R2 logical producer");
    issue_op(5'd22, 1, ARI, 5'd3, 5'd0, 0, 1, 0, "R2 logical adjacent");
    nops(6);

    // Register zero (R7)
    issue_op(5'd0, 1, ARI, 5'd1, 5'd2, 0, 0, 0, "R7 writer of r0");
    issue_op(5'd23, 1, LOG, 5'd0, 5'd0, 0, 0, 0, "R7 reader of r0");
    nops(6);

    // Non-writing producer (R10)
    issue_op(5'd7, 0, ARI, 5'd1, 5'd2, 0, 0, 0, "R10 non-writing producer");
    issue_op(5'd24, 1, LOG, 5'd7, 5'd7, 0, 0, 0, "R10 reader");
    nops(6);

    // Independent operands, then bubble placement (R9, R8)
    issue_op(5'd11, 1, LOG, 5'd1, 5'd0, 0, 0, 0, "R9 logical producer");
    issue_op(5'd12, 1, ARI, 5'd1, 5'd0, 0, 0, 0, "R9 arith producer");
    issue_op(5'd13, 1, LOG, 5'd12, 5'd11, 1, 2, 3, "R9 two operands");
    issue_op(5'd14, 1, ARI, 5'd13, 5'd12, 0, 1, 3, "R8 bubble shifts older producer");
    nops(6);

    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    finish_run();
  end

endmodule